// File: doc/BRIEF.md
# Virtual-Link Transmit Schedule Builder

This block turns a per-link timing configuration into one merged transmit schedule for a single cluster cycle. Each virtual link is described by two numbers, both in units of 0.1 ms: a first-send offset from the cycle start, and a repeat period. Software first writes these numbers, together with the cluster cycle length and an enable mask, through a simple register-write port. It then pulses `start`. The block walks the links' send times in ascending order and writes one entry per transmit event into an internal schedule memory. A timer-driven dispatcher later reads that memory through a read port.

The result has three parts: a start tick, which is the time of the first event; a list of entries; and a count of those entries. Each entry names the link to serve at its event and gives the delay until the following event. The dispatcher fires the link of entry 0 at the start tick. It then waits that entry's delay, fires the link of entry 1, and continues in the same way. Generation uses a greedy rule: it always selects the link whose running next-send time is smallest. It stops once that smallest time lies beyond the cluster cycle. It also stops, and raises an error, if the memory fills first.

Top module: `vl_sched_gen`

## Requirements
- R1: Configuration writes use `cfg_addr`. When bit 4 is 0, bits 3..1 select the link and bit 0 selects the field: 0 is the offset, 1 is the period. When bit 4 is 1, bit 0 selects the global field: 0 is the cluster cycle length, 1 is the link enable mask (bit i enables link i). All register fields reset to zero.
- R2: A `start` pulse is accepted only while `busy` is low, and `busy` is high from the next cycle until completion. While `busy` is high, further `start` pulses and configuration writes have no effect.
- R3: The start tick equals the smallest offset among enabled links. Entry 0 names that link.
- R4: Each link's running time begins at its offset and grows by its period each time the link is placed. The delay of entry k equals the smallest running time after entry k's link has been advanced, minus entry k's event time. Entry k+1 names the link that holds that smallest time.
- R5: Equal running times are served lowest link index first, so the earlier of two tied entries has delay 0.
- R6: After writing an entry, generation ends if the smallest running time is strictly greater than the cluster cycle. The final entry's delay is still written, and a time exactly equal to the cluster cycle still gets an entry. `sched_len` then holds the number of entries written.
- R7: The memory holds 64 entries. If entry 63 is written and the next time is still within the cycle, generation ends with `ovf_err` high and `sched_len` equal to 64. `ovf_err` is cleared by the next accepted `start`.
- R8: With no link enabled, the run ends with `sched_len` 0, start tick 0 and `ovf_err` low.
- R9: Entries are read through `rd_addr`, and `rd_link` and `rd_delay` show that entry one clock later.
- R10: `done` is a single-cycle pulse, raised in the same cycle that `busy` falls. After reset, `busy`, `done`, `ovf_err`, `sched_len` and `start_tick` are all zero.
- R11: A link whose enable bit is clear never appears in the schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Begin generation |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf_err | output | 1 | Schedule memory ran out |
| start_tick | output | 16 | Time of the first event |
| sched_len | output | 7 | Number of valid entries |
| rd_addr | input | 6 | Entry read address |
| rd_link | output | 3 | Link of the addressed entry |
| rd_delay | output | 16 | Delay following the addressed entry |

## Verification
A fault in the minimum search or a misplaced advance shows up in the schedule itself. It appears either as a wrong link index or as a delay that is off by a period, in the first entry after the faulty selection. It therefore surfaces on the read port within one read of that entry. A wrong stop comparison changes `sched_len` by one, and this is visible as soon as `done` pulses. A wrong first pick corrupts `start_tick` and entry 0 together. Sweeping offsets and periods over small grids, against an arithmetic model, drives ties, equal-to-cycle events and disabled links through each of these paths.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    GS_IDLE,
    GS_LOAD,
    GS_FIRST,
    GS_STEP
  } gen_state_e;

  // address decode codes
  localparam logic SEL_LINK   = 1'b0;
  localparam logic SEL_GLOBAL = 1'b1;
  localparam logic FLD_OFFSET = 1'b0;
  localparam logic FLD_PERIOD = 1'b1;
  localparam logic FLD_CYCLE  = 1'b0;
  localparam logic FLD_MASK   = 1'b1;
endpackage

// File: rtl/vsg_cfg_regs.sv
module vsg_cfg_regs #(
  parameter int NL = 8,
  parameter int TW = 16,
  parameter int LW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic                   lock,
  input  logic [LW+1:0]          addr,
  input  logic [TW-1:0]          wdata,
  output logic [NL-1:0][TW-1:0]  offset_q,
  output logic [NL-1:0][TW-1:0]  period_q,
  output logic [TW-1:0]          cycle_q,
  output logic [NL-1:0]          mask_q
);
  import vsg_pkg::*;

  logic          wr_ok;
  logic          is_global;
  logic          fld;
  logic [LW-1:0] idx;

  assign wr_ok     = we && !lock;
  assign is_global = (addr[LW+1] == SEL_GLOBAL);
  assign fld       = addr[0];
  assign idx       = addr[LW:1];

  for (genvar g = 0; g < NL; g++) begin : g_link
    logic hit;
    assign hit = wr_ok && !is_global && (idx == LW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        offset_q[g] <= '0;
        period_q[g] <= '0;
      end else if (hit) begin
        if (fld == FLD_OFFSET) offset_q[g] <= wdata;
        else                   period_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q <= '0;
      mask_q  <= '0;
    end else if (wr_ok && is_global) begin
      if (fld == FLD_CYCLE) cycle_q <= wdata;
      else                  mask_q  <= wdata[NL-1:0];
    end
  end
endmodule

// File: rtl/vsg_min_select.sv
module vsg_min_select #(
  parameter int NL = 8,
  parameter int RW = 17,
  parameter int LW = 3
) (
  input  logic [NL-1:0][RW-1:0] vals,
  input  logic [NL-1:0]         valid,
  output logic [RW-1:0]         min_val,
  output logic [LW-1:0]         min_idx,
  output logic                  any_valid
);
  // ascending scan with strict compare: ties go to the lowest index
  always_comb begin
    min_val   = '0;
    min_idx   = '0;
    any_valid = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if (valid[i] && (!any_valid || (vals[i] < min_val))) begin
        min_val   = vals[i];
        min_idx   = LW'(i);
        any_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vsg_sched_mem.sv
module vsg_sched_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 19,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= mem[raddr];
  end
endmodule

// File: rtl/vl_sched_gen.sv
module vl_sched_gen #(
  parameter int NUM_LINKS   = 8,
  parameter int MAX_ENTRIES = 64,
  parameter int TW          = 16,
  localparam int LW  = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int EAW = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CW  = $clog2(MAX_ENTRIES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [LW+1:0]  cfg_addr,
  input  logic [TW-1:0]  cfg_wdata,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           ovf_err,
  output logic [TW-1:0]  start_tick,
  output logic [CW-1:0]  sched_len,
  input  logic [EAW-1:0] rd_addr,
  output logic [LW-1:0]  rd_link,
  output logic [TW-1:0]  rd_delay
);
  import vsg_pkg::*;

  localparam int RW = TW + 1;
  localparam int DW = LW + TW;

  // arithmetic kept in functions
  function automatic logic [RW-1:0] advance(input logic [RW-1:0] t, input logic [TW-1:0] p);
    return t + {1'b0, p};
  endfunction

  function automatic logic [TW-1:0] gap(input logic [RW-1:0] later, input logic [RW-1:0] earlier);
    logic [RW-1:0] d;
    d = later - earlier;
    return d[TW-1:0];
  endfunction

  function automatic logic beyond(input logic [RW-1:0] t, input logic [TW-1:0] c);
    return t > {1'b0, c};
  endfunction

  // configuration
  logic [NUM_LINKS-1:0][TW-1:0] offset_q;
  logic [NUM_LINKS-1:0][TW-1:0] period_q;
  logic [TW-1:0]                cycle_q;
  logic [NUM_LINKS-1:0]         mask_q;

  // generation state
  gen_state_e                   state_q;
  logic [NUM_LINKS-1:0][RW-1:0] run_q;
  logic [RW-1:0]                last_q;
  logic [LW-1:0]                pend_q;
  logic [EAW-1:0]               cnt_q;
  logic                         busy_q;
  logic                         done_q;
  logic                         ovf_q;
  logic [TW-1:0]                start_q;
  logic [CW-1:0]                len_q;

  // named internal events
  logic [RW-1:0] min_val;
  logic [LW-1:0] min_idx;
  logic          any_valid;
  logic          accept_start;
  logic          in_first;
  logic          in_step;
  logic          entry_we;
  logic          past_end;
  logic          table_full;
  logic          first_empty;
  logic          sel_adv;
  logic [EAW-1:0] wr_addr;
  logic [LW-1:0]  wr_link;
  logic [TW-1:0]  wr_delay;
  logic [DW-1:0]  rd_word;

  vsg_cfg_regs #(.NL(NUM_LINKS), .TW(TW), .LW(LW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .lock     (busy_q),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .offset_q (offset_q),
    .period_q (period_q),
    .cycle_q  (cycle_q),
    .mask_q   (mask_q)
  );

  vsg_min_select #(.NL(NUM_LINKS), .RW(RW), .LW(LW)) u_min (
    .vals      (run_q),
    .valid     (mask_q),
    .min_val   (min_val),
    .min_idx   (min_idx),
    .any_valid (any_valid)
  );

  assign accept_start = start && (state_q == GS_IDLE);
  assign in_first     = (state_q == GS_FIRST);
  assign in_step      = (state_q == GS_STEP);
  assign entry_we     = in_step;
  assign past_end     = beyond(min_val, cycle_q);
  assign table_full   = (cnt_q == EAW'(MAX_ENTRIES - 1));
  assign first_empty  = in_first && !any_valid;
  assign sel_adv      = (in_first && any_valid) || (in_step && !past_end && !table_full);
  assign wr_addr      = cnt_q;
  assign wr_link      = pend_q;
  assign wr_delay     = gap(min_val, last_q);

  // running next-send time per link
  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_run
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[g] <= '0;
      end else if (state_q == GS_LOAD) begin
        run_q[g] <= {1'b0, offset_q[g]};
      end else if (sel_adv && (min_idx == LW'(g))) begin
        run_q[g] <= advance(run_q[g], period_q[g]);
      end
    end
  end

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      last_q  <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        GS_IDLE: begin
          if (accept_start) begin
            state_q <= GS_LOAD;
            busy_q  <= 1'b1;
            ovf_q   <= 1'b0;
            start_q <= '0;
            len_q   <= '0;
          end
        end
        GS_LOAD: state_q <= GS_FIRST;
        GS_FIRST: begin
          if (first_empty) begin
            state_q <= GS_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            start_q <= min_val[TW-1:0];
            last_q  <= min_val;
            pend_q  <= min_idx;
            cnt_q   <= '0;
            state_q <= GS_STEP;
          end
        end
        GS_STEP: begin
          if (past_end) begin
            len_q   <= CW'(cnt_q) + CW'(1);
            state_q <= GS_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end else if (table_full) begin
            len_q   <= CW'(MAX_ENTRIES);
            ovf_q   <= 1'b1;
            state_q <= GS_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            pend_q <= min_idx;
            last_q <= min_val;
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        default: state_q <= GS_IDLE;
      endcase
    end
  end

  vsg_sched_mem #(.DEPTH(MAX_ENTRIES), .DW(DW), .AW(EAW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (entry_we),
    .waddr (wr_addr),
    .wdata ({wr_link, wr_delay}),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  assign rd_link    = rd_word[DW-1:TW];
  assign rd_delay   = rd_word[TW-1:0];
  assign busy       = busy_q;
  assign done       = done_q;
  assign ovf_err    = ovf_q;
  assign start_tick = start_q;
  assign sched_len  = len_q;
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int NL  = 8,
  parameter int ME  = 64,
  parameter int TW  = 16,
  parameter int LW  = 3,
  parameter int EAW = 6,
  parameter int CW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           ovf_err,
  input logic [CW-1:0]  sched_len,
  input logic           cfg_we,
  input logic [TW-1:0]  cycle_q,
  input logic [NL-1:0]  mask_q,
  input logic           entry_we,
  input logic [EAW-1:0] wr_addr,
  input logic [LW-1:0]  wr_link,
  input logic [TW:0]    cur_min,
  input logic [TW:0]    last_val
);
  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we |=> $stable(cycle_q));

  a_r4_time_order: assert property (@(posedge clk) disable iff (!rst_n)
    entry_we |-> cur_min >= last_val);

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    entry_we && $past(entry_we) |-> wr_addr == $past(wr_addr) + 1'b1);

  a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sched_len <= CW'(ME));

  a_r7_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> sched_len == CW'(ME));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r11_enabled_link: assert property (@(posedge clk) disable iff (!rst_n)
    entry_we |-> mask_q[wr_link]);
endmodule

bind vl_sched_gen vsg_checker #(
  .NL(NUM_LINKS), .ME(MAX_ENTRIES), .TW(TW), .LW(LW), .EAW(EAW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .ovf_err   (ovf_err),
  .sched_len (sched_len),
  .cfg_we    (cfg_we),
  .cycle_q   (cycle_q),
  .mask_q    (mask_q),
  .entry_we  (entry_we),
  .wr_addr   (wr_addr),
  .wr_link   (wr_link),
  .cur_min   (min_val),
  .last_val  (last_q)
);

// File: tb/vl_sched_gen_bench.sv
`timescale 1ns/1ps
module vl_sched_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        busy, done, ovf_err;
  logic [15:0] start_tick;
  logic [6:0]  sched_len;
  logic [5:0]  rd_addr = '0;
  logic [2:0]  rd_link;
  logic [15:0] rd_delay;

  always #4 clk = ~clk;

  vl_sched_gen u_vl_sched_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .busy(busy), .done(done),
    .ovf_err(ovf_err), .start_tick(start_tick), .sched_len(sched_len),
    .rd_addr(rd_addr), .rd_link(rd_link), .rd_delay(rd_delay)
  );

  int n_checks = 0;
  int n_fails  = 0;

  // model configuration and expectation
  int m_off[8];
  int m_per[8];
  int m_cycle;
  bit [7:0] m_mask;
  int e_link[64];
  int e_gap[64];
  int e_len;
  int e_start;
  int e_ovf;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin m_off[i] = 0; m_per[i] = 0; end
    m_cycle = 0;
    m_mask = '0;
  endtask

  // event-driven view: advance each link's next time, always serve the earliest
  task automatic model_build();
    int nxt[8];
    int cur, t_now, best, bt;
    for (int i = 0; i < 8; i++) nxt[i] = m_off[i];
    e_len = 0; e_start = 0; e_ovf = 0;
    best = -1; bt = 0;
    for (int i = 0; i < 8; i++)
      if (m_mask[i] && (best < 0 || nxt[i] < bt)) begin best = i; bt = nxt[i]; end
    if (best < 0) return;
    e_start = bt; cur = best; t_now = bt;
    nxt[best] += m_per[best];
    forever begin
      best = -1; bt = 0;
      for (int i = 0; i < 8; i++)
        if (m_mask[i] && (best < 0 || nxt[i] < bt)) begin best = i; bt = nxt[i]; end
      e_link[e_len] = cur;
      e_gap[e_len]  = bt - t_now;
      e_len++;
      if (bt > m_cycle) break;
      if (e_len == 64) begin e_ovf = 1; break; end
      cur = best; t_now = bt;
      nxt[best] += m_per[best];
    end
  endtask

  task automatic reg_write(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_cfg();
    for (int i = 0; i < 8; i++) begin
      reg_write(i * 2, m_off[i]);
      reg_write(i * 2 + 1, m_per[i]);
    end
    reg_write(16, m_cycle);
    reg_write(17, int'(m_mask));
  endtask

  task automatic launch();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check(tag, "done seen", int'(done), 1);
  endtask

  task automatic verify(input string tag);
    model_build();
    check(tag, "start_tick (R3)", int'(start_tick), e_start);
    check(tag, "sched_len (R6)", int'(sched_len), e_len);
    check(tag, "ovf_err (R7)", int'(ovf_err), e_ovf);
    @(negedge clk);
    check(tag, "done one cycle (R10)", int'(done), 0);
    check(tag, "busy low (R10)", int'(busy), 0);
    for (int k = 0; k < e_len; k++) begin
      rd_addr = 6'(k);
      @(negedge clk);
      check(tag, $sformatf("entry %0d link (R9)", k), int'(rd_link), e_link[k]);
      check(tag, $sformatf("entry %0d delay (R9)", k), int'(rd_delay), e_gap[k]);
    end
  endtask

  task automatic run_case(input string tag);
    load_cfg();
    launch();
    wait_done(tag);
    verify(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "reset busy", int'(busy), 0);
    check("R10", "reset done", int'(done), 0);
    check("R10", "reset ovf", int'(ovf_err), 0);
    check("R10", "reset len", int'(sched_len), 0);
    check("R10", "reset start_tick", int'(start_tick), 0);

    // R8: nothing enabled
    model_clear();
    m_cycle = 50;
    m_off[0] = 5; m_per[0] = 5;
    run_case("R8");

    // R3/R4: two-link reference pattern
    model_clear();
    m_off[0] = 26; m_per[0] = 40;
    m_off[1] = 10; m_per[1] = 20;
    m_cycle = 80; m_mask = 8'b0000_0011;
    run_case("R4");
    check("R3", "vector start tick", int'(start_tick), 10);
    check("R6", "vector length", int'(sched_len), 6);

    // R2: start and config writes during busy have no effect
    launch();
    start = 1'b1;
    reg_write(16, 5);
    start = 1'b0;
    wait_done("R2");
    verify("R2");
    launch();
    wait_done("R2");
    verify("R2");

    // R5: tie order
    model_clear();
    m_off[3] = 5; m_per[3] = 10;
    m_off[6] = 5; m_per[6] = 10;
    m_cycle = 20; m_mask = 8'b0100_1000;
    run_case("R5");
    rd_addr = 6'd0;
    @(negedge clk);
    check("R5", "tie first link", int'(rd_link), 3);
    check("R5", "tie zero delay", int'(rd_delay), 0);

    // R6: event exactly at cycle end still scheduled
    model_clear();
    m_off[2] = 0; m_per[2] = 10;
    m_cycle = 20; m_mask = 8'b0000_0100;
    run_case("R6");
    check("R6", "equal-to-cycle length", int'(sched_len), 3);

    // R7: overflow
    model_clear();
    m_off[7] = 0; m_per[7] = 1;
    m_cycle = 1000; m_mask = 8'b1000_0000;
    run_case("R7");
    check("R7", "overflow flag", int'(ovf_err), 1);
    // R7: error cleared by next start
    m_cycle = 3;
    run_case("R7");

    // R11: disabled link with the smallest offset
    model_clear();
    m_off[0] = 9;  m_per[0] = 7;
    m_off[1] = 0;  m_per[1] = 3;
    m_off[2] = 4;  m_per[2] = 5;
    m_cycle = 30; m_mask = 8'b0000_0101;
    run_case("R11");

    // R1/R4: sweeps over two and three links
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int p = 0; p < 3; p++)
          for (int q = 0; q < 3; q++) begin
            model_clear();
            m_off[4] = a * 3 + (a == 2 ? 1 : 0);
            m_off[5] = b * 3;
            m_per[4] = 4 + p * 3;
            m_per[5] = 3 + q * 4;
            m_cycle = 30; m_mask = 8'b0011_0000;
            run_case("R1/R4 sweep2");
          end
    for (int p = 0; p < 3; p++)
      for (int q = 0; q < 3; q++)
        for (int r = 0; r < 3; r++) begin
          model_clear();
          m_off[0] = 2; m_off[1] = 0; m_off[2] = 5;
          m_per[0] = 5 + p * 2;
          m_per[1] = 6 + q * 3;
          m_per[2] = 4 + r * 5;
          m_cycle = 40 + p; m_mask = 8'b0000_0111;
          run_case("R1/R5 sweep3");
        end

    summary();
    $finish;
  end
endmodule